// File: doc/BRIEF.md
# Watermark Read/Write Command Scheduler

This block picks, once per cycle, at most one command for one memory channel from a read queue and a write queue. Each queue entry shows whether it is occupied, whether its next command may go out this cycle, what that next command is (activate, precharge, column read or column write), and the rank and bank it targets. A per-bank precharging flag, the occupancy of both queues, and an optional activate candidate offered by an outside selector complete the inputs. The output is the chosen entry's index, the queue it came from and its command type. The block also keeps a running count of the precharges it lets through.

The scheduler alternates between a read-favouring mode and a write-drain mode. Drain mode is entered when the write queue fills past a high mark or when there are no reads at all. It is left once the write occupancy falls to a low mark. In either mode, column commands to already open rows ("hits") win first. A precharge is only released when no other entry in its own queue still wants a column access to that bank, and when the bank is not already closing. The selection is combinational from the current inputs and the mode register, so the grant is valid in the same cycle the inputs are presented.

Top module: `cmd_scheduler`

## Requirements
- R1: The mode register stays in drain only while it was in drain in the previous cycle and the write occupancy is strictly above LO_MARK. A read-mode register stays in read mode while the write occupancy is at most HI_MARK and the read occupancy is nonzero. The decision of a cycle becomes visible on `drainMode` after the next rising clock edge.
- R2: Drain is forced in the same cycle when the write occupancy is strictly above HI_MARK, or when the read occupancy is zero.
- R3: In drain mode the grant goes to the first write entry whose command is column write. Failing that, it goes to the first eligible write entry of any command. Failing that, it goes to the first read entry whose command is column read.
- R4: In read mode the grant goes to the first read entry whose command is column read. Failing that, it goes to the first eligible read entry. Failing that, it goes to the first write entry whose command is column write.
- R5: A precharge entry is not eligible while the bank it targets is closing. The bank's flag sits at bit position rank*BANKS+bank of `bankPrecharging`.
- R6: A precharge entry is not eligible while any occupied entry of the same queue with the same rank and bank has the column command of that queue (column read for the read queue, column write for the write queue). That other entry need not be issuable.
- R7: `preCount` rises by one on the clock edge after a cycle in which a precharge is granted, and holds otherwise. It wraps at 2^CNT_W.
- R8: In read mode, when the first eligible read entry has an activate as its next command and `actPickValid` is high, the grant is the read queue entry at `actPickIdx`, with command activate.
- R9: "First" means the lowest index. An entry is considered only when both its occupied and issuable flags are set. Command codes are 0 activate, 1 precharge, 2 column read and 3 column write.
- R10: `grantValid` is low when no rule above yields a candidate. After reset `drainMode` and `preCount` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdOcc | input | OCC_W | Read queue occupancy |
| wrOcc | input | OCC_W | Write queue occupancy |
| rdValid | input | QDEPTH | Read entry occupied flags |
| rdIssuable | input | QDEPTH | Read entry may issue this cycle |
| rdCmd | input | 2*QDEPTH | Read entry next command, 2 bits per entry |
| rdRank | input | RANK_W*QDEPTH | Read entry rank |
| rdBank | input | BANK_W*QDEPTH | Read entry bank |
| wrValid | input | QDEPTH | Write entry occupied flags |
| wrIssuable | input | QDEPTH | Write entry may issue this cycle |
| wrCmd | input | 2*QDEPTH | Write entry next command |
| wrRank | input | RANK_W*QDEPTH | Write entry rank |
| wrBank | input | BANK_W*QDEPTH | Write entry bank |
| bankPrecharging | input | RANKS*BANKS | Bank closing flags |
| actPickValid | input | 1 | Outside activate candidate present |
| actPickIdx | input | IDX_W | Read queue index of that candidate |
| grantValid | output | 1 | A command is chosen this cycle |
| grantFromWrite | output | 1 | 1 if the chosen entry is in the write queue |
| grantIdx | output | IDX_W | Index of the chosen entry |
| grantCmd | output | 2 | Command type of the chosen entry |
| drainMode | output | 1 | Mode register (1 = write drain) |
| preCount | output | CNT_W | Precharges granted, wrapping |

## Verification
The bench builds the block with four entries per queue, two ranks of two banks, a 4-bit occupancy with marks 6 and 4, and a 4-bit counter. Random occupancies therefore cross both marks often, so entry into drain, the hysteresis band and the exit from drain all happen within a short run. Random addresses collide on the same rank and bank often enough that both precharge filters fire regularly. Granting seventeen precharges in a row takes the counter through its wrap.

// File: rtl/cmdsched_pkg.sv
package cmdsched_pkg;

  typedef enum logic [1:0] {
    CMD_ACT   = 2'd0,
    CMD_PRE   = 2'd1,
    CMD_COLRD = 2'd2,
    CMD_COLWR = 2'd3
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic drainActive;
    logic actSwapOk;
  } sched_strobe_t;

endpackage

// File: rtl/sched_queue_scan.sv
module sched_queue_scan
  import cmdsched_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int RANKS  = 2,
  parameter int BANKS  = 8,
  parameter logic [1:0] COL_CMD = CMD_COLRD,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int SLOTS  = RANKS * BANKS,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [QDEPTH-1:0]        valid,
  input  logic [QDEPTH-1:0]        issuable,
  input  logic [2*QDEPTH-1:0]      cmdVec,
  input  logic [RANK_W*QDEPTH-1:0] rankVec,
  input  logic [BANK_W*QDEPTH-1:0] bankVec,
  input  logic [SLOTS-1:0]         precharging,
  output logic                     hitFound,
  output logic [IDX_W-1:0]         hitIdx,
  output logic                     anyFound,
  output logic [IDX_W-1:0]         anyIdx,
  output logic [1:0]               anyCmd
);

  logic [1:0]        cmdArr  [QDEPTH];
  logic [RANK_W-1:0] rankArr [QDEPTH];
  logic [BANK_W-1:0] bankArr [QDEPTH];
  logic [SLOT_W-1:0] slotArr [QDEPTH];
  logic [QDEPTH-1:0] colHere;
  logic [QDEPTH-1:0] preBlocked;
  logic [QDEPTH-1:0] hitReq;
  logic [QDEPTH-1:0] anyReq;

  for (genvar i = 0; i < QDEPTH; i++) begin : g_unpack
    assign cmdArr[i]  = cmdVec[2*i +: 2];
    assign rankArr[i] = rankVec[RANK_W*i +: RANK_W];
    assign bankArr[i] = bankVec[BANK_W*i +: BANK_W];
    assign slotArr[i] = SLOT_W'(rankArr[i]) * SLOT_W'(BANKS) + SLOT_W'(bankArr[i]);
    assign colHere[i] = valid[i] && (cmdArr[i] == COL_CMD);
    assign hitReq[i]  = colHere[i] && issuable[i];
    assign anyReq[i]  = valid[i] && issuable[i] && !preBlocked[i];
  end

  // a precharge waits while its bank is closing or still has a column user
  always_comb begin
    preBlocked = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (cmdArr[i] == CMD_PRE) begin
        if (precharging[slotArr[i]]) preBlocked[i] = 1'b1;
        for (int j = 0; j < QDEPTH; j++) begin
          if (colHere[j] && rankArr[j] == rankArr[i] && bankArr[j] == bankArr[i])
            preBlocked[i] = 1'b1;
        end
      end
    end
  end

  // lowest index wins: scan from the top down
  always_comb begin
    hitFound = 1'b0;
    hitIdx   = '0;
    anyFound = 1'b0;
    anyIdx   = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (hitReq[i]) begin
        hitFound = 1'b1;
        hitIdx   = IDX_W'(i);
      end
      if (anyReq[i]) begin
        anyFound = 1'b1;
        anyIdx   = IDX_W'(i);
      end
    end
  end

  assign anyCmd = cmdArr[anyIdx];

endmodule

// File: rtl/sched_datapath.sv
module sched_datapath
  import cmdsched_pkg::*;
#(
  parameter int QDEPTH = 8,
  parameter int RANKS  = 2,
  parameter int BANKS  = 8,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  sched_strobe_t              strb,
  input  logic [QDEPTH-1:0]          rdValid,
  input  logic [QDEPTH-1:0]          rdIssuable,
  input  logic [2*QDEPTH-1:0]        rdCmd,
  input  logic [RANK_W*QDEPTH-1:0]   rdRank,
  input  logic [BANK_W*QDEPTH-1:0]   rdBank,
  input  logic [QDEPTH-1:0]          wrValid,
  input  logic [QDEPTH-1:0]          wrIssuable,
  input  logic [2*QDEPTH-1:0]        wrCmd,
  input  logic [RANK_W*QDEPTH-1:0]   wrRank,
  input  logic [BANK_W*QDEPTH-1:0]   wrBank,
  input  logic [RANKS*BANKS-1:0]     bankPrecharging,
  input  logic [IDX_W-1:0]           actPickIdx,
  output logic                       grantValid,
  output logic                       grantFromWrite,
  output logic [IDX_W-1:0]           grantIdx,
  output logic [1:0]                 grantCmd
);

  logic             rdHitFound, rdAnyFound, wrHitFound, wrAnyFound;
  logic [IDX_W-1:0] rdHitIdx, rdAnyIdx, wrHitIdx, wrAnyIdx;
  logic [1:0]       rdAnyCmd, wrAnyCmd;

  sched_queue_scan #(.QDEPTH(QDEPTH), .RANKS(RANKS), .BANKS(BANKS), .COL_CMD(CMD_COLRD)) u_rdScan (
    .valid(rdValid), .issuable(rdIssuable), .cmdVec(rdCmd), .rankVec(rdRank),
    .bankVec(rdBank), .precharging(bankPrecharging),
    .hitFound(rdHitFound), .hitIdx(rdHitIdx),
    .anyFound(rdAnyFound), .anyIdx(rdAnyIdx), .anyCmd(rdAnyCmd)
  );

  sched_queue_scan #(.QDEPTH(QDEPTH), .RANKS(RANKS), .BANKS(BANKS), .COL_CMD(CMD_COLWR)) u_wrScan (
    .valid(wrValid), .issuable(wrIssuable), .cmdVec(wrCmd), .rankVec(wrRank),
    .bankVec(wrBank), .precharging(bankPrecharging),
    .hitFound(wrHitFound), .hitIdx(wrHitIdx),
    .anyFound(wrAnyFound), .anyIdx(wrAnyIdx), .anyCmd(wrAnyCmd)
  );

  always_comb begin
    grantValid     = 1'b0;
    grantFromWrite = 1'b0;
    grantIdx       = '0;
    grantCmd       = CMD_ACT;
    if (strb.drainActive) begin
      if (wrHitFound) begin
        grantValid = 1'b1; grantFromWrite = 1'b1; grantIdx = wrHitIdx; grantCmd = CMD_COLWR;
      end else if (wrAnyFound) begin
        grantValid = 1'b1; grantFromWrite = 1'b1; grantIdx = wrAnyIdx; grantCmd = wrAnyCmd;
      end else if (rdHitFound) begin
        grantValid = 1'b1; grantIdx = rdHitIdx; grantCmd = CMD_COLRD;
      end
    end else begin
      if (rdHitFound) begin
        grantValid = 1'b1; grantIdx = rdHitIdx; grantCmd = CMD_COLRD;
      end else if (rdAnyFound) begin
        grantValid = 1'b1;
        if (rdAnyCmd == CMD_ACT && strb.actSwapOk) begin
          grantIdx = actPickIdx; grantCmd = CMD_ACT;
        end else begin
          grantIdx = rdAnyIdx; grantCmd = rdAnyCmd;
        end
      end else if (wrHitFound) begin
        grantValid = 1'b1; grantFromWrite = 1'b1; grantIdx = wrHitIdx; grantCmd = CMD_COLWR;
      end
    end
  end

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import cmdsched_pkg::*;
#(
  parameter int OCC_W   = 7,
  parameter int HI_MARK = 60,
  parameter int LO_MARK = 50,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [OCC_W-1:0]   rdOcc,
  input  logic [OCC_W-1:0]   wrOcc,
  input  logic               actPickValid,
  input  logic               grantValid,
  input  logic [1:0]         grantCmd,
  output sched_strobe_t      strb,
  output logic               drainMode,
  output logic [CNT_W-1:0]   preCount
);

  localparam logic [OCC_W-1:0] HI_LVL = OCC_W'(HI_MARK);
  localparam logic [OCC_W-1:0] LO_LVL = OCC_W'(LO_MARK);

  logic drainQ;
  logic drainNow;

  // hysteresis first, then the forcing conditions
  assign drainNow = (drainQ && (wrOcc > LO_LVL)) || (wrOcc > HI_LVL) || (rdOcc == '0);

  assign strb.drainActive = drainNow;
  assign strb.actSwapOk   = actPickValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drainQ   <= 1'b0;
      preCount <= '0;
    end else begin
      drainQ <= drainNow;
      if (grantValid && grantCmd == CMD_PRE) preCount <= preCount + CNT_W'(1);
    end
  end

  assign drainMode = drainQ;

endmodule

// File: rtl/cmd_scheduler.sv
module cmd_scheduler
  import cmdsched_pkg::*;
#(
  parameter int QDEPTH  = 8,
  parameter int RANKS   = 2,
  parameter int BANKS   = 8,
  parameter int OCC_W   = 7,
  parameter int HI_MARK = 60,
  parameter int LO_MARK = 50,
  parameter int CNT_W   = 16,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [OCC_W-1:0]          rdOcc,
  input  logic [OCC_W-1:0]          wrOcc,
  input  logic [QDEPTH-1:0]         rdValid,
  input  logic [QDEPTH-1:0]         rdIssuable,
  input  logic [2*QDEPTH-1:0]       rdCmd,
  input  logic [RANK_W*QDEPTH-1:0]  rdRank,
  input  logic [BANK_W*QDEPTH-1:0]  rdBank,
  input  logic [QDEPTH-1:0]         wrValid,
  input  logic [QDEPTH-1:0]         wrIssuable,
  input  logic [2*QDEPTH-1:0]       wrCmd,
  input  logic [RANK_W*QDEPTH-1:0]  wrRank,
  input  logic [BANK_W*QDEPTH-1:0]  wrBank,
  input  logic [RANKS*BANKS-1:0]    bankPrecharging,
  input  logic                      actPickValid,
  input  logic [IDX_W-1:0]          actPickIdx,
  output logic                      grantValid,
  output logic                      grantFromWrite,
  output logic [IDX_W-1:0]          grantIdx,
  output logic [1:0]                grantCmd,
  output logic                      drainMode,
  output logic [CNT_W-1:0]          preCount
);

  sched_strobe_t strb;

  sched_ctrl #(.OCC_W(OCC_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdOcc(rdOcc), .wrOcc(wrOcc), .actPickValid(actPickValid),
    .grantValid(grantValid), .grantCmd(grantCmd), .strb(strb),
    .drainMode(drainMode), .preCount(preCount)
  );

  sched_datapath #(.QDEPTH(QDEPTH), .RANKS(RANKS), .BANKS(BANKS)) u_dp (
    .strb(strb),
    .rdValid(rdValid), .rdIssuable(rdIssuable), .rdCmd(rdCmd), .rdRank(rdRank), .rdBank(rdBank),
    .wrValid(wrValid), .wrIssuable(wrIssuable), .wrCmd(wrCmd), .wrRank(wrRank), .wrBank(wrBank),
    .bankPrecharging(bankPrecharging), .actPickIdx(actPickIdx),
    .grantValid(grantValid), .grantFromWrite(grantFromWrite), .grantIdx(grantIdx), .grantCmd(grantCmd)
  );

endmodule

// File: rtl/sched_checker.sv
module sched_checker
  import cmdsched_pkg::*;
#(
  parameter int QDEPTH  = 8,
  parameter int RANKS   = 2,
  parameter int BANKS   = 8,
  parameter int OCC_W   = 7,
  parameter int HI_MARK = 60,
  parameter int LO_MARK = 50,
  parameter int CNT_W   = 16,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int IDX_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [OCC_W-1:0]          rdOcc,
  input logic [OCC_W-1:0]          wrOcc,
  input logic [QDEPTH-1:0]         rdValid,
  input logic [QDEPTH-1:0]         rdIssuable,
  input logic [2*QDEPTH-1:0]       rdCmd,
  input logic [RANK_W*QDEPTH-1:0]  rdRank,
  input logic [BANK_W*QDEPTH-1:0]  rdBank,
  input logic [QDEPTH-1:0]         wrValid,
  input logic [QDEPTH-1:0]         wrIssuable,
  input logic [2*QDEPTH-1:0]       wrCmd,
  input logic [RANK_W*QDEPTH-1:0]  wrRank,
  input logic [BANK_W*QDEPTH-1:0]  wrBank,
  input logic [RANKS*BANKS-1:0]    bankPrecharging,
  input logic                      actPickValid,
  input logic [IDX_W-1:0]          actPickIdx,
  input logic                      grantValid,
  input logic                      grantFromWrite,
  input logic [IDX_W-1:0]          grantIdx,
  input logic [1:0]                grantCmd,
  input logic                      drainMode,
  input logic [CNT_W-1:0]          preCount
);

  localparam logic [OCC_W-1:0] HI_LVL = OCC_W'(HI_MARK);
  localparam logic [OCC_W-1:0] LO_LVL = OCC_W'(LO_MARK);

  logic [RANK_W-1:0] gRank;
  logic [BANK_W-1:0] gBank;
  logic              gBankClosing;
  logic              anyHit;

  always_comb begin
    gRank = grantFromWrite ? wrRank[RANK_W*grantIdx +: RANK_W] : rdRank[RANK_W*grantIdx +: RANK_W];
    gBank = grantFromWrite ? wrBank[BANK_W*grantIdx +: BANK_W] : rdBank[BANK_W*grantIdx +: BANK_W];
    gBankClosing = bankPrecharging[int'(gRank) * BANKS + int'(gBank)];
    anyHit = 1'b0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (rdValid[i] && rdIssuable[i] && rdCmd[2*i +: 2] == CMD_COLRD) anyHit = 1'b1;
      if (wrValid[i] && wrIssuable[i] && wrCmd[2*i +: 2] == CMD_COLWR) anyHit = 1'b1;
    end
  end

  a_r1_stay_read: assert property (@(posedge clk) disable iff (!rstN)
    (!drainMode && wrOcc <= HI_LVL && rdOcc != '0) |=> !drainMode);

  a_r1_drain_exit: assert property (@(posedge clk) disable iff (!rstN)
    (wrOcc <= LO_LVL && rdOcc != '0) |=> !drainMode);

  a_r2_high_mark: assert property (@(posedge clk) disable iff (!rstN)
    (wrOcc > HI_LVL || rdOcc == '0) |=> drainMode);

  a_r5_closing_bank: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantCmd == CMD_PRE) |-> !gBankClosing);

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantCmd == CMD_PRE) |=> (preCount == $past(preCount) + CNT_W'(1)));

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && grantCmd == CMD_PRE) |=> $stable(preCount));

  a_r8_swap_idx: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantFromWrite && grantCmd == CMD_ACT && actPickValid) |-> (grantIdx == actPickIdx));

  a_r9_rd_eligible: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !grantFromWrite && grantCmd != CMD_ACT) |->
      (rdValid[grantIdx] && rdIssuable[grantIdx] && rdCmd[2*grantIdx +: 2] == grantCmd));

  a_r9_wr_eligible: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && grantFromWrite) |->
      (wrValid[grantIdx] && wrIssuable[grantIdx] && wrCmd[2*grantIdx +: 2] == grantCmd));

  a_r10_idle_no_hits: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> !anyHit);

endmodule

bind cmd_scheduler sched_checker #(
  .QDEPTH(QDEPTH), .RANKS(RANKS), .BANKS(BANKS), .OCC_W(OCC_W),
  .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .CNT_W(CNT_W)
) u_schedChk (
  .clk(clk), .rstN(rstN), .rdOcc(rdOcc), .wrOcc(wrOcc),
  .rdValid(rdValid), .rdIssuable(rdIssuable), .rdCmd(rdCmd), .rdRank(rdRank), .rdBank(rdBank),
  .wrValid(wrValid), .wrIssuable(wrIssuable), .wrCmd(wrCmd), .wrRank(wrRank), .wrBank(wrBank),
  .bankPrecharging(bankPrecharging), .actPickValid(actPickValid), .actPickIdx(actPickIdx),
  .grantValid(grantValid), .grantFromWrite(grantFromWrite), .grantIdx(grantIdx),
  .grantCmd(grantCmd), .drainMode(drainMode), .preCount(preCount)
);

// File: tb/test_cmd_scheduler.sv
module test_cmd_scheduler;

  localparam int QD = 4;
  localparam int NR = 2;
  localparam int NB = 2;
  localparam int OW = 4;
  localparam int HI = 6;
  localparam int LO = 4;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [OW-1:0] rdOcc, wrOcc;
  logic [QD-1:0] rdValid, rdIssuable, wrValid, wrIssuable;
  logic [2*QD-1:0] rdCmd, wrCmd;
  logic [QD-1:0] rdRank, rdBank, wrRank, wrBank;
  logic [NR*NB-1:0] bankPrecharging;
  logic actPickValid;
  logic [1:0] actPickIdx;
  logic grantValid, grantFromWrite, drainMode;
  logic [1:0] grantIdx, grantCmd;
  logic [CW-1:0] preCount;

  always #5 clk = ~clk;

  cmd_scheduler #(.QDEPTH(QD), .RANKS(NR), .BANKS(NB), .OCC_W(OW),
                  .HI_MARK(HI), .LO_MARK(LO), .CNT_W(CW)) i_cmd_scheduler (
    .clk(clk), .rstN(rstN), .rdOcc(rdOcc), .wrOcc(wrOcc),
    .rdValid(rdValid), .rdIssuable(rdIssuable), .rdCmd(rdCmd), .rdRank(rdRank), .rdBank(rdBank),
    .wrValid(wrValid), .wrIssuable(wrIssuable), .wrCmd(wrCmd), .wrRank(wrRank), .wrBank(wrBank),
    .bankPrecharging(bankPrecharging), .actPickValid(actPickValid), .actPickIdx(actPickIdx),
    .grantValid(grantValid), .grantFromWrite(grantFromWrite), .grantIdx(grantIdx),
    .grantCmd(grantCmd), .drainMode(drainMode), .preCount(preCount)
  );

  // stimulus state: queue 0 = read, 1 = write
  int qv[2][QD], qi[2][QD], qc[2][QD], qr[2][QD], qb[2][QD];
  int prech[NR*NB];
  int aV, aI, rO, wO;

  int total = 0;
  int bad = 0;
  int mDrain = 0;
  int mCount = 0;
  int eV, eW, eIdx, eCmd, eDn;
  string eTag;

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clearAll();
    for (int q = 0; q < 2; q++)
      for (int i = 0; i < QD; i++) begin
        qv[q][i] = 0; qi[q][i] = 0; qc[q][i] = 0; qr[q][i] = 0; qb[q][i] = 0;
      end
    for (int s = 0; s < NR*NB; s++) prech[s] = 0;
    aV = 0; aI = 0; rO = 3; wO = 0;
  endtask

  task automatic setEntry(int q, int i, int v, int iss, int c, int r, int b);
    qv[q][i] = v; qi[q][i] = iss; qc[q][i] = c; qr[q][i] = r; qb[q][i] = b;
  endtask

  task automatic drive();
    rdOcc = OW'(rO); wrOcc = OW'(wO);
    actPickValid = aV[0]; actPickIdx = 2'(aI);
    for (int i = 0; i < QD; i++) begin
      rdValid[i] = qv[0][i][0]; rdIssuable[i] = qi[0][i][0];
      rdCmd[2*i +: 2] = 2'(qc[0][i]); rdRank[i] = qr[0][i][0]; rdBank[i] = qb[0][i][0];
      wrValid[i] = qv[1][i][0]; wrIssuable[i] = qi[1][i][0];
      wrCmd[2*i +: 2] = 2'(qc[1][i]); wrRank[i] = qr[1][i][0]; wrBank[i] = qb[1][i][0];
    end
    for (int s = 0; s < NR*NB; s++) bankPrecharging[s] = prech[s][0];
  endtask

  function automatic bit preHeld(int q, int i);
    if (qc[q][i] != 1) return 1'b0;
    if (prech[qr[q][i]*NB + qb[q][i]] != 0) return 1'b1;
    for (int j = 0; j < QD; j++)
      if (qv[q][j] != 0 && qc[q][j] == 2 + q && qr[q][j] == qr[q][i] && qb[q][j] == qb[q][i])
        return 1'b1;
    return 1'b0;
  endfunction

  function automatic int firstHit(int q);
    for (int i = 0; i < QD; i++)
      if (qv[q][i] != 0 && qi[q][i] != 0 && qc[q][i] == 2 + q) return i;
    return -1;
  endfunction

  function automatic int firstAny(int q);
    for (int i = 0; i < QD; i++)
      if (qv[q][i] != 0 && qi[q][i] != 0 && !preHeld(q, i)) return i;
    return -1;
  endfunction

  task automatic pick(int w, int idx, int c, string tag);
    eV = 1; eW = w; eIdx = idx; eCmd = c; eTag = tag;
  endtask

  task automatic predict();
    int h, a, x;
    eDn = ((mDrain != 0 && wO > LO) || wO > HI || rO == 0) ? 1 : 0;
    eV = 0; eW = 0; eIdx = 0; eCmd = 0; eTag = "R10";
    if (eDn != 0) begin
      h = firstHit(1); a = firstAny(1); x = firstHit(0);
      if (h >= 0) pick(1, h, 3, "R3");
      else if (a >= 0) pick(1, a, qc[1][a], (qc[1][a] == 1) ? "R6" : "R3");
      else if (x >= 0) pick(0, x, 2, "R3");
    end else begin
      h = firstHit(0); a = firstAny(0); x = firstHit(1);
      if (h >= 0) pick(0, h, 2, "R4");
      else if (a >= 0) begin
        if (qc[0][a] == 0 && aV != 0) pick(0, aI, 0, "R8");
        else pick(0, a, qc[0][a], (qc[0][a] == 1) ? "R5" : "R4");
      end
      else if (x >= 0) pick(1, x, 3, "R4");
    end
  endtask

  // one cycle: entered at a falling edge, leaves at the next falling edge
  task automatic cycle(string tag);
    string t;
    drive();
    #1;
    predict();
    t = (tag.len() != 0) ? tag : eTag;
    check(t, int'(grantValid), eV, "grantValid");
    if (eV != 0) begin
      check(t, int'(grantFromWrite), eW, "grantFromWrite");
      check(t, int'(grantIdx), eIdx, "grantIdx");
      check(t, int'(grantCmd), eCmd, "grantCmd");
    end
    check("R1", int'(drainMode), mDrain, "drainMode");
    check("R7", int'(preCount), mCount, "preCount");
    @(posedge clk);
    mDrain = eDn;
    if (eV != 0 && eCmd == 1) mCount = (mCount + 1) % (1 << CW);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearAll();
    drive();
    repeat (3) @(negedge clk);
    check("R10", int'(drainMode), 0, "reset drainMode");
    check("R10", int'(preCount), 0, "reset preCount");
    rstN = 1'b1;

    // R10: nothing eligible in read mode
    cycle("R10");

    // R4 / R9: lowest read hit beats an earlier activate
    clearAll();
    setEntry(0, 0, 1, 1, 0, 0, 0);
    setEntry(0, 1, 1, 0, 2, 0, 1);
    setEntry(0, 2, 1, 1, 2, 1, 0);
    setEntry(0, 3, 1, 1, 2, 1, 1);
    cycle("R9");

    // R4 + R7: unblocked read precharge is taken, counter follows
    clearAll();
    setEntry(0, 1, 1, 1, 1, 1, 1);
    setEntry(0, 2, 1, 1, 0, 0, 0);
    cycle("R4");
    cycle("R7");

    // R6: column read pending (not issuable) on the same bank holds the precharge
    clearAll();
    setEntry(0, 0, 1, 1, 1, 0, 1);
    setEntry(0, 1, 1, 1, 0, 1, 0);
    setEntry(0, 3, 1, 0, 2, 0, 1);
    cycle("R6");

    // R5: closing bank holds the precharge (slot rank1*2+bank0 = 2)
    clearAll();
    setEntry(0, 0, 1, 1, 1, 1, 0);
    setEntry(0, 2, 1, 1, 0, 0, 1);
    prech[2] = 1;
    cycle("R5");

    // R8: outside activate candidate replaces the first activate
    aV = 1; aI = 3;
    cycle("R8");

    // R4: no read eligible, write hit served in read mode
    clearAll();
    setEntry(0, 0, 1, 0, 0, 0, 0);
    setEntry(1, 1, 1, 1, 3, 0, 0);
    setEntry(1, 2, 1, 1, 3, 1, 1);
    cycle("R4");

    // R2 / R3: high mark forces drain; write hit beats write activate
    clearAll();
    wO = 7;
    setEntry(1, 0, 1, 1, 0, 0, 0);
    setEntry(1, 2, 1, 1, 3, 1, 0);
    setEntry(0, 0, 1, 1, 2, 0, 0);
    cycle("R2");
    // R1: still draining above the low mark
    wO = 5;
    setEntry(1, 2, 0, 0, 0, 0, 0);
    cycle("R1");
    // R1: at the low mark drain ends, read hit wins
    wO = 4;
    cycle("R1");
    cycle("R1");

    // R2: empty read queue forces drain
    clearAll();
    rO = 0; wO = 1;
    setEntry(1, 1, 1, 1, 0, 1, 1);
    cycle("R2");

    // R3: drain with no eligible write falls back to a read hit
    clearAll();
    wO = 9;
    setEntry(1, 0, 1, 1, 1, 0, 0);
    setEntry(1, 1, 1, 0, 3, 0, 0);
    setEntry(0, 3, 1, 1, 2, 1, 1);
    cycle("R3");

    // R7: run the counter through its wrap
    clearAll();
    setEntry(0, 0, 1, 1, 1, 0, 0);
    for (int k = 0; k < 17; k++) cycle("R7");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int q = 0; q < 2; q++)
        for (int i = 0; i < QD; i++)
          setEntry(q, i, ($urandom % 4) != 0, $urandom % 2, $urandom % 4, $urandom % NR, $urandom % NB);
      for (int s = 0; s < NR*NB; s++) prech[s] = (($urandom % 4) == 0) ? 1 : 0;
      aV = $urandom % 2; aI = $urandom % QD;
      rO = $urandom % 8; wO = $urandom % 10;
      cycle("");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule